// File: doc/BRIEF.md
# Two-Level Translation Table Walker

The walker turns a 32-bit virtual address into a physical address by reading a two-level page table from memory. A request brings a virtual address and the upper bits of a first-level table base. The walker issues one word read for the first-level descriptor and decodes its 2-bit type. A section is resolved at once. A coarse or fine second-level table starts a second word read. A fault ends the walk. Each second-level table kind has its own base mask and index width.

The result is a one-cycle response. It carries the physical address, the 4-bit domain taken from the first-level descriptor, and bits [11:2] of the final descriptor, passed through without interpretation. It also carries a fault code that says which level failed. Only one walk is in flight at a time. The block checks no permissions and caches nothing.

Top module: `xlat_walker`

## Requirements
- R1: After synchronous reset, req_ready is 1 and both rsp_valid and mem_req are 0.
- R2: The first read of a walk is at address {tbl_base, vaddr[31:20], 2'b00}, where tbl_base holds address bits [31:14].
- R3: A first-level descriptor with bits [1:0] = 00 ends the walk after one read with rsp_fault = 01 and rsp_paddr = 0.
- R4: A first-level descriptor with bits [1:0] = 10 (1 MB section) ends the walk after one read with rsp_fault = 00 and rsp_paddr = {desc[31:20], vaddr[19:0]}.
- R5: A first-level descriptor with bits [1:0] = 01 (coarse table) leads to a second read at {desc[31:10], vaddr[19:12], 2'b00}.
- R6: A first-level descriptor with bits [1:0] = 11 (fine table) leads to a second read at {desc[31:12], vaddr[19:10], 2'b00}.
- R7: A second-level descriptor with bits [1:0] = 00 gives rsp_fault = 10 and rsp_paddr = 0.
- R8: A second-level descriptor with bits [1:0] = 01 (64 KB page) gives rsp_paddr = {desc[31:16], vaddr[15:0]} and rsp_fault = 00.
- R9: A second-level descriptor with bits [1:0] = 10 (4 KB page) gives rsp_paddr = {desc[31:12], vaddr[11:0]} and rsp_fault = 00.
- R10: A second-level descriptor with bits [1:0] = 11 (1 KB page) gives rsp_paddr = {desc[31:10], vaddr[9:0]} and rsp_fault = 00.
- R11: rsp_domain always equals bits [8:5] of the first-level descriptor. rsp_attr always equals bits [11:2] of the last descriptor read.
- R12: mem_req is a one-cycle pulse, and at most one read is outstanding. req_ready is 0 from the cycle after a request is accepted until the response cycle. req_ready is 1 again in the response cycle, so the next request can be accepted in that cycle.
- R13: rsp_valid is a one-cycle pulse in the cycle after the mem_rvalid that ends the walk. rsp_fault is never 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted when req_valid is high |
| req_vaddr | input | 32 | Virtual address to translate |
| tbl_base | input | 18 | First-level table base, address bits [31:14] |
| mem_req | output | 1 | One-cycle word read request |
| mem_addr | output | 32 | Word address of the read |
| mem_rvalid | input | 1 | Read data valid, at least one cycle after mem_req |
| mem_rdata | input | 32 | Read data word |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| rsp_domain | output | 4 | Domain from the first-level descriptor |
| rsp_attr | output | 10 | Bits [11:2] of the last descriptor read |
| rsp_fault | output | 2 | 00 none, 01 first-level fault, 10 second-level fault |

## Verification
A response going out and the next request coming in can fall in the same cycle. The bench provokes this by holding req_valid high through a run of back-to-back walks, each queued behind the previous one. The monitor requires req_ready to be high whenever rsp_valid is seen. The read-address scoreboard then requires the next first-level read to match the newly accepted address. The memory model changes its latency on every read, so response timing and second-level read issue are judged at varied distances from the request.

// File: rtl/xw_pkg.sv
package xw_pkg;
  localparam int ADDR_W  = 32;
  localparam int DOM_W   = 4;
  localparam int ATTR_W  = 10;
  localparam int BASE_LO = 14;

  typedef enum logic [1:0] {
    K_FAULT   = 2'b00,
    K_COARSE  = 2'b01,
    K_SECTION = 2'b10,
    K_FINE    = 2'b11
  } l1_kind_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_L1   = 2'b01,
    FLT_L2   = 2'b10
  } fault_e;
endpackage

// File: rtl/xw_l1_decode.sv
module xw_l1_decode
  import xw_pkg::*;
(
  input  logic [ADDR_W-1:0] desc,
  input  logic [19:0]       va_lo,
  output l1_kind_e          kind,
  output logic [ADDR_W-1:0] sect_pa,
  output logic [ADDR_W-1:0] next_addr,
  output logic [DOM_W-1:0]  domain,
  output logic [ATTR_W-1:0] attr
);
  assign kind    = l1_kind_e'(desc[1:0]);
  assign domain  = desc[8:5];
  assign attr    = desc[11:2];
  assign sect_pa = {desc[31:20], va_lo};

  // coarse tables index 256 words, fine tables 1024 words
  always_comb begin
    if (kind == K_FINE)
      next_addr = {desc[31:12], va_lo[19:10], 2'b00};
    else
      next_addr = {desc[31:10], va_lo[19:12], 2'b00};
  end
endmodule

// File: rtl/xw_l2_decode.sv
module xw_l2_decode
  import xw_pkg::*;
(
  input  logic [ADDR_W-1:0] desc,
  input  logic [15:0]       va_lo,
  output logic [ADDR_W-1:0] page_pa,
  output logic              fault,
  output logic [ATTR_W-1:0] attr
);
  assign attr = desc[11:2];

  always_comb begin
    fault = 1'b0;
    unique case (desc[1:0])
      2'b01:   page_pa = {desc[31:16], va_lo};
      2'b10:   page_pa = {desc[31:12], va_lo[11:0]};
      2'b11:   page_pa = {desc[31:10], va_lo[9:0]};
      default: begin
        page_pa = '0;
        fault   = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xw_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [ADDR_W-1:0]         req_vaddr,
  input  logic [ADDR_W-1:BASE_LO]   tbl_base,
  output logic                      mem_req,
  output logic [ADDR_W-1:0]         mem_addr,
  input  logic                      mem_rvalid,
  input  logic [ADDR_W-1:0]         mem_rdata,
  output logic                      rsp_valid,
  output logic [ADDR_W-1:0]         rsp_paddr,
  output logic [DOM_W-1:0]          rsp_domain,
  output logic [ATTR_W-1:0]         rsp_attr,
  output logic [1:0]                rsp_fault
);
  typedef enum logic [1:0] {S_IDLE, S_LVL1, S_LVL2} state_e;

  state_e            state;
  logic [19:0]       va_q;
  logic [DOM_W-1:0]  dom_q;

  l1_kind_e          k1;
  logic [ADDR_W-1:0] sect_pa, l2_addr, page_pa;
  logic [DOM_W-1:0]  dom1;
  logic [ATTR_W-1:0] attr1, attr2;
  logic              flt2;

  xw_l1_decode u_l1 (
    .desc(mem_rdata), .va_lo(va_q), .kind(k1), .sect_pa(sect_pa),
    .next_addr(l2_addr), .domain(dom1), .attr(attr1)
  );

  xw_l2_decode u_l2 (
    .desc(mem_rdata), .va_lo(va_q[15:0]), .page_pa(page_pa),
    .fault(flt2), .attr(attr2)
  );

  assign req_ready = (state == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      va_q       <= '0;
      dom_q      <= '0;
      mem_req    <= 1'b0;
      mem_addr   <= '0;
      rsp_valid  <= 1'b0;
      rsp_paddr  <= '0;
      rsp_domain <= '0;
      rsp_attr   <= '0;
      rsp_fault  <= FLT_NONE;
    end else begin
      mem_req   <= 1'b0;
      rsp_valid <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (req_valid) begin
            va_q     <= req_vaddr[19:0];
            mem_req  <= 1'b1;
            mem_addr <= {tbl_base, req_vaddr[31:20], 2'b00};
            state    <= S_LVL1;
          end
        end
        S_LVL1: begin
          if (mem_rvalid) begin
            dom_q <= dom1;
            unique case (k1)
              K_FAULT: begin
                rsp_valid  <= 1'b1;
                rsp_paddr  <= '0;
                rsp_domain <= dom1;
                rsp_attr   <= attr1;
                rsp_fault  <= FLT_L1;
                state      <= S_IDLE;
              end
              K_SECTION: begin
                rsp_valid  <= 1'b1;
                rsp_paddr  <= sect_pa;
                rsp_domain <= dom1;
                rsp_attr   <= attr1;
                rsp_fault  <= FLT_NONE;
                state      <= S_IDLE;
              end
              default: begin
                mem_req  <= 1'b1;
                mem_addr <= l2_addr;
                state    <= S_LVL2;
              end
            endcase
          end
        end
        S_LVL2: begin
          if (mem_rvalid) begin
            rsp_valid  <= 1'b1;
            rsp_paddr  <= page_pa;
            rsp_domain <= dom_q;
            rsp_attr   <= attr2;
            rsp_fault  <= flt2 ? FLT_L2 : FLT_NONE;
            state      <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk
  import xw_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rvalid,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic [1:0]        rsp_fault
);
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (req_ready && !rsp_valid && !mem_req));

  a_r12_req_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  a_r12_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  a_r12_ready_at_rsp: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> req_ready);

  a_r12_word_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  a_r13_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  a_r13_rsp_follows_data: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(mem_rvalid));

  a_r13_fault_code: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_fault != 2'b11));

  a_r3_fault_zero_pa: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault != 2'b00) |-> (rsp_paddr == '0));
endmodule

bind xlat_walker xlat_walker_chk i_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
  .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
);

// File: tb/test_xlat_walker.sv
module test_xlat_walker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [17:0] tbl_base = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [3:0]  rsp_domain;
  logic [9:0]  rsp_attr;
  logic [1:0]  rsp_fault;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  xlat_walker i_xlat_walker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .tbl_base(tbl_base), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_domain(rsp_domain),
    .rsp_attr(rsp_attr), .rsp_fault(rsp_fault)
  );

  // sparse table memory, absent words read as 0 (fault descriptor)
  logic [31:0] bmem [logic [31:0]];
  function automatic logic [31:0] rd(input logic [31:0] a);
    return bmem.exists(a) ? bmem[a] : 32'h0;
  endfunction

  logic        pend = 1'b0;
  logic [31:0] pa_q = '0;
  int          cnt = 0;
  int          lat = 1;
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (rst) pend <= 1'b0;
    else if (mem_req) begin
      pend <= 1'b1; pa_q <= mem_addr; cnt <= lat;
      lat  <= (lat % 3) + 1;
    end else if (pend) begin
      if (cnt <= 1) begin
        mem_rvalid <= 1'b1; mem_rdata <= rd(pa_q); pend <= 1'b0;
      end else cnt <= cnt - 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboards
  logic [31:0] q_addr[$];
  string       q_atag[$];
  logic [31:0] q_pa[$];
  logic [1:0]  q_flt[$];
  logic [3:0]  q_dom[$];
  logic [9:0]  q_attr[$];
  string       q_tag[$];

  always @(negedge clk) begin
    if (!rst && mem_req) begin
      if (q_addr.size() == 0) chk(0, "R12 unexpected read", mem_addr, 32'h0);
      else begin
        logic [31:0] e; string t;
        e = q_addr.pop_front(); t = q_atag.pop_front();
        chk(mem_addr == e, t, mem_addr, e);
      end
    end
    if (!rst && rsp_valid) begin
      chk(req_ready == 1'b1, "R12 ready in response cycle", {31'h0, req_ready}, 32'h1);
      if (q_pa.size() == 0) chk(0, "R13 unexpected response", rsp_paddr, 32'h0);
      else begin
        logic [31:0] ep; logic [1:0] ef; logic [3:0] ed; logic [9:0] ea; string t;
        ep = q_pa.pop_front(); ef = q_flt.pop_front(); ed = q_dom.pop_front();
        ea = q_attr.pop_front(); t = q_tag.pop_front();
        chk(rsp_paddr == ep, {t, " paddr"}, rsp_paddr, ep);
        chk(rsp_fault == ef, {t, " fault"}, {30'h0, rsp_fault}, {30'h0, ef});
        chk(rsp_domain == ed, {t, " R11 domain"}, {28'h0, rsp_domain}, {28'h0, ed});
        chk(rsp_attr == ea, {t, " R11 attr"}, {22'h0, rsp_attr}, {22'h0, ea});
      end
    end
  end

  // reference model built from the requirements
  task automatic walk(input logic [31:0] va);
    logic [31:0] a1, d1, a2, d2, pa;
    logic [1:0] f;
    string t;
    a1 = {tbl_base, va[31:20], 2'b00};
    d1 = rd(a1);
    q_addr.push_back(a1); q_atag.push_back("R2 first-level address");
    case (d1[1:0])
      2'b00: begin pa = 0; f = 2'b01; t = "R3 first-level fault"; d2 = d1; end
      2'b10: begin pa = {d1[31:20], va[19:0]}; f = 2'b00; t = "R4 section"; d2 = d1; end
      default: begin
        if (d1[1:0] == 2'b01) begin
          a2 = {d1[31:10], va[19:12], 2'b00};
          q_atag.push_back("R5 coarse address");
        end else begin
          a2 = {d1[31:12], va[19:10], 2'b00};
          q_atag.push_back("R6 fine address");
        end
        q_addr.push_back(a2);
        d2 = rd(a2);
        case (d2[1:0])
          2'b00: begin pa = 0; f = 2'b10; t = "R7 second-level fault"; end
          2'b01: begin pa = {d2[31:16], va[15:0]}; f = 0; t = "R8 large page"; end
          2'b10: begin pa = {d2[31:12], va[11:0]}; f = 0; t = "R9 small page"; end
          default: begin pa = {d2[31:10], va[9:0]}; f = 0; t = "R10 tiny page"; end
        endcase
      end
    endcase
    q_pa.push_back(pa); q_flt.push_back(f); q_dom.push_back(d1[8:5]);
    q_attr.push_back(d2[11:2]); q_tag.push_back(t);
    // drive, holding the request until accepted
    req_valid = 1'b1; req_vaddr = va;
    forever begin
      bit rdy;
      rdy = req_ready;
      @(posedge clk);
      @(negedge clk);
      if (rdy) break;
    end
    req_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 40 && q_pa.size() != 0; i++) @(negedge clk);
  endtask

  logic [31:0] va_list [10];

  initial begin
    logic [31:0] d1c, d1f;
    tbl_base = 18'h00010;                      // table at 0x0004_0000
    d1c = 32'h0080_1400 | (32'd9 << 5) | 32'h1;
    d1f = 32'h00A0_3000 | (32'd15 << 5) | 32'h3;
    bmem[{tbl_base, 12'h123, 2'b00}] = 32'hABC0_0000 | (32'd5 << 5) | (32'd3 << 10) | 32'hE;
    bmem[{tbl_base, 12'hFFF, 2'b00}] = 32'hFFF0_0000 | (32'd15 << 5) | (32'd3 << 10) | 32'h2;
    bmem[{tbl_base, 12'h200, 2'b00}] = d1c;
    bmem[{tbl_base, 12'h3FF, 2'b00}] = d1f;
    bmem[{d1c[31:10], 8'h34, 2'b00}] = 32'h7777_0000 | 32'hFF0 | 32'hD;
    bmem[{d1c[31:10], 8'h56, 2'b00}] = 32'h1357_9000 | 32'hAA0 | 32'h2;
    bmem[{d1c[31:10], 8'hFF, 2'b00}] = 32'h5555_5400 | 32'h3;
    bmem[{d1f[31:12], 10'h26A, 2'b00}] = 32'h0BAD_C400 | 32'h30 | 32'h3;
    bmem[{d1f[31:12], 10'h000, 2'b00}] = 32'h2468_A000 | 32'h550 | 32'h6;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 reset ready", {31'h0, req_ready}, 32'h1);
    chk(rsp_valid == 1'b0, "R1 reset rsp_valid", {31'h0, rsp_valid}, 32'h0);
    chk(mem_req == 1'b0, "R1 reset mem_req", {31'h0, mem_req}, 32'h0);

    va_list = '{32'h1234_5678, 32'h0050_0000, 32'h2003_4ABC, 32'h2005_6DEF,
                32'h2007_7000, 32'h3FF9_ABCD, 32'h3FF0_0123, 32'hFFFF_FFFF,
                32'h200F_F3FF, 32'h0000_0000};
    // isolated walks
    foreach (va_list[i]) begin
      walk(va_list[i]);
      drain();
      repeat (2) @(negedge clk);
    end
    // back-to-back walks: response and next acceptance share a cycle
    for (int r = 0; r < 3; r++)
      foreach (va_list[i]) walk(va_list[(i + r) % 10]);
    drain();
    repeat (6) @(negedge clk);
    chk(q_addr.size() == 0, "R12 all reads issued", q_addr.size(), 0);
    chk(q_pa.size() == 0, "R13 all responses seen", q_pa.size(), 0);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL R13 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule